// File: doc/BRIEF.md
# Timer and Watchdog with Shared Prescaler

This block pairs an 8-bit timer/counter with a watchdog counter, and the two share a single 8-bit prescaler. A control bit gives the prescaler to one of them. The other then counts every source event without division. The timer counts either an instruction-cycle enable pulse or edges on an external count pin. The pin is synchronized first, and a control bit selects which edge counts. The watchdog counts pulses from an independent free-running clock, which arrive as a tick input. When an enabled watchdog runs through its full range it raises a one-cycle reset request.

The processor side of the chip drives the block through write strobes for the control byte, the timer value and the watchdog enable. It also drives command pulses for clearing the watchdog and for entering sleep. The prescaler is a down-counter, and its present value is visible on an output for readback. A timer rollover sets a sticky flag, which software clears.

Top module: `timer_watchdog`

## Requirements
- R1: After reset the control byte reads 8'hBF, the prescaler reads 8'hFF, the timer reads 0, the overflow flag and reset request are 0, and the watchdog enable reads 1. The control byte layout is: bit 0 timer source (1 = pin), bit 1 edge (1 = falling), bit 2 prescaler owner (1 = watchdog), bits 5:3 ratio, bit 6 interrupt enable, bit 7 spare.
- R2: With source bit 0 and the prescaler owned by the watchdog, the timer advances by one on every clock where `cyc_tick` is high, and the prescaler does not change.
- R3: With source bit 1, the timer counts rising pin edges when the edge bit is 0 and falling edges when it is 1. The opposite edge never counts. A pin change made before clock edge k shows in the timer after clock edge k+2.
- R4: With the prescaler owned by the timer and ratio r, every timer event decrements the prescaler by one. The timer advances once per 2^(r+1) events, on the event that finds the low r+1 prescaler bits all zero.
- R5: A timer write loads the written value and takes priority over counting in that cycle. It reloads the prescaler to all ones only when the prescaler is owned by the timer, and otherwise leaves the prescaler unchanged.
- R6: The overflow flag sets when the timer counts from 8'hFF to 8'h00 and stays set until `ovf_clr`. A set and a clear in the same cycle leave the flag set.
- R7: With the prescaler owned by the watchdog and ratio r, the watchdog counter advances once per 2^r watchdog ticks. The advance that wraps the 8-bit counter raises `wdt_rst_req` for exactly one cycle.
- R8: `wdt_clear` and `sleep_enter` each zero the watchdog counter. They reload the prescaler to all ones only when the prescaler is owned by the watchdog.
- R9: While the watchdog enable is 0, watchdog ticks are ignored: no reset request is raised and the prescaler does not move.
- R10: With the prescaler owned by the timer, the watchdog counts every tick undivided (time-out after 256 ticks), and watchdog ticks leave the prescaler unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data |
| ctl_q | output | 8 | Control byte readback |
| wdt_en_we | input | 1 | Watchdog enable write strobe |
| wdt_en_d | input | 1 | Watchdog enable write data |
| wdt_en_q | output | 1 | Watchdog enable readback |
| cyc_tick | input | 1 | Instruction-cycle count enable |
| cnt_pin | input | 1 | Asynchronous external count pin |
| tmr_we | input | 1 | Timer write strobe |
| tmr_wdata | input | 8 | Timer write data |
| tmr_q | output | 8 | Timer value |
| ovf_clr | input | 1 | Clears the overflow flag |
| ovf_flag | output | 1 | Sticky timer overflow flag |
| wdt_tick | input | 1 | Tick from the free-running watchdog clock |
| wdt_clear | input | 1 | Watchdog clear command |
| sleep_enter | input | 1 | Sleep command (clears like `wdt_clear`) |
| wdt_rst_req | output | 1 | One-cycle watchdog reset request |
| pre_q | output | 8 | Prescaler down-counter value |

## Verification
The bench targets the uneven ratio tables. A design that used one table for both owners would advance the timer twice as often, or the watchdog half as often. It checks that each clear reaches the prescaler only in the right ownership state; a design that always cleared it would lose counts, and the bench sees the prescaler value jump. Pin edge polarity and the two-stage synchronizer latency are checked one cycle at a time, which exposes a missing or extra stage. Overflow set-versus-clear priority and the silence of a disabled watchdog over more than a full period are also checked.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int CTL_W   = 8;
  localparam int RATIO_W = 3;

  typedef struct packed {
    logic               spare;
    logic               int_en;
    logic [RATIO_W-1:0] ratio;
    logic               pre_wdt;
    logic               edge_fall;
    logic               src_pin;
  } tw_ctl_t;

  localparam logic [CTL_W-1:0] CTL_RST = 8'hBF;
endpackage

// File: rtl/tw_pin_sync.sv
module tw_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic edge_fall,
  output logic pin_ev
);
  logic [STAGES-1:0] stage_d;
  logic [STAGES-1:0] stage_q;
  logic              prev_q;
  logic              level;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      assign stage_d[i] = pin;
    end else begin : g_next
      assign stage_d[i] = stage_q[i-1];
    end
  end

  assign level = stage_q[STAGES-1];

  always_comb begin
    if (edge_fall) pin_ev = prev_q & ~level;
    else           pin_ev = ~prev_q & level;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      stage_q <= stage_d;
      prev_q  <= level;
    end
  end
endmodule

// File: rtl/tw_prescaler.sv
module tw_prescaler #(
  parameter int PRE_W   = 8,
  parameter int RATIO_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ev,
  input  logic               clr,
  input  logic               to_wdt,
  input  logic [RATIO_W-1:0] ratio,
  output logic               div_pulse,
  output logic [PRE_W-1:0]   cnt_q
);
  logic [RATIO_W:0] shamt;
  logic [PRE_W:0]   span;
  logic [PRE_W:0]   cnt_ext;
  logic [PRE_W-1:0] cnt_d;
  logic             low_zero;

  always_comb begin
    if (to_wdt) shamt = {1'b0, ratio};
    else        shamt = {1'b0, ratio} + 1'b1;
    span     = ((PRE_W+1)'(1) << shamt) - (PRE_W+1)'(1);
    cnt_ext  = {1'b0, cnt_q};
    low_zero = ((cnt_ext & span) == '0);
    div_pulse = ev && !clr && low_zero;
  end

  always_comb begin
    cnt_d = cnt_q;
    if (clr)     cnt_d = '1;
    else if (ev) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '1;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tw_timer.sv
module tw_timer #(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [TMR_W-1:0] wdata,
  input  logic             inc,
  input  logic             ovf_clr,
  output logic [TMR_W-1:0] q,
  output logic             ovf
);
  logic [TMR_W-1:0] q_d;
  logic             ovf_d;
  logic             wrap;

  always_comb begin
    wrap  = !we && inc && (q == '1);
    q_d   = q;
    ovf_d = ovf;
    if (we)       q_d = wdata;
    else if (inc) q_d = q + 1'b1;
    if (wrap)         ovf_d = 1'b1;
    else if (ovf_clr) ovf_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q   <= '0;
      ovf <= 1'b0;
    end else begin
      q   <= q_d;
      ovf <= ovf_d;
    end
  end
endmodule

// File: rtl/tw_watchdog.sv
module tw_watchdog #(
  parameter int WDT_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic adv,
  input  logic clr,
  output logic req
);
  logic [WDT_W-1:0] cnt_q;
  logic [WDT_W-1:0] cnt_d;
  logic             step;
  logic             req_d;

  always_comb begin
    step  = adv && en && !clr;
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (step) cnt_d = cnt_q + 1'b1;
    req_d = step && (cnt_q == '1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      req   <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      req   <= req_d;
    end
  end
endmodule

// File: rtl/timer_watchdog.sv
module timer_watchdog
  import tw_pkg::*;
#(
  parameter int PRE_W  = 8,
  parameter int TMR_W  = 8,
  parameter int WDT_W  = 8,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_q,
  input  logic             wdt_en_we,
  input  logic             wdt_en_d,
  output logic             wdt_en_q,
  input  logic             cyc_tick,
  input  logic             cnt_pin,
  input  logic             tmr_we,
  input  logic [TMR_W-1:0] tmr_wdata,
  output logic [TMR_W-1:0] tmr_q,
  input  logic             ovf_clr,
  output logic             ovf_flag,
  input  logic             wdt_tick,
  input  logic             wdt_clear,
  input  logic             sleep_enter,
  output logic             wdt_rst_req,
  output logic [PRE_W-1:0] pre_q
);
  tw_ctl_t          ctl_r;
  logic [CTL_W-1:0] ctl_d;
  logic             wen_d;
  logic             pin_ev;
  logic             tmr_ev;
  logic             wdt_ev;
  logic             pre_ev;
  logic             pre_clr;
  logic             div_pulse;
  logic             tmr_inc;
  logic             wdt_adv;
  logic             wdt_clr_any;

  always_comb begin
    ctl_d = ctl_r;
    if (ctl_we) ctl_d = ctl_wdata;
    wen_d = wdt_en_q;
    if (wdt_en_we) wen_d = wdt_en_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_r    <= CTL_RST;
      wdt_en_q <= 1'b1;
    end else begin
      ctl_r    <= ctl_d;
      wdt_en_q <= wen_d;
    end
  end

  assign ctl_q = ctl_r;

  tw_pin_sync #(.STAGES(SYNC_N)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin       (cnt_pin),
    .edge_fall (ctl_r.edge_fall),
    .pin_ev    (pin_ev)
  );

  always_comb begin
    wdt_clr_any = wdt_clear | sleep_enter;
    tmr_ev      = ctl_r.src_pin ? pin_ev : cyc_tick;
    wdt_ev      = wdt_tick & wdt_en_q;
    if (ctl_r.pre_wdt) begin
      pre_ev  = wdt_ev;
      pre_clr = wdt_clr_any;
      tmr_inc = tmr_ev;
      wdt_adv = div_pulse;
    end else begin
      pre_ev  = tmr_ev;
      pre_clr = tmr_we;
      tmr_inc = div_pulse;
      wdt_adv = wdt_ev;
    end
  end

  tw_prescaler #(.PRE_W(PRE_W), .RATIO_W(RATIO_W)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev        (pre_ev),
    .clr       (pre_clr),
    .to_wdt    (ctl_r.pre_wdt),
    .ratio     (ctl_r.ratio),
    .div_pulse (div_pulse),
    .cnt_q     (pre_q)
  );

  tw_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (tmr_we),
    .wdata   (tmr_wdata),
    .inc     (tmr_inc),
    .ovf_clr (ovf_clr),
    .q       (tmr_q),
    .ovf     (ovf_flag)
  );

  tw_watchdog #(.WDT_W(WDT_W)) u_wdt (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (wdt_en_q),
    .adv   (wdt_adv),
    .clr   (wdt_clr_any),
    .req   (wdt_rst_req)
  );
endmodule

// File: rtl/tw_checker.sv
module tw_checker #(
  parameter int PRE_W = 8,
  parameter int TMR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       ctl_q,
  input logic             tmr_we,
  input logic [TMR_W-1:0] tmr_wdata,
  input logic [TMR_W-1:0] tmr_q,
  input logic             ovf_flag,
  input logic             wdt_clear,
  input logic             sleep_enter,
  input logic             wdt_en_q,
  input logic             wdt_rst_req,
  input logic [PRE_W-1:0] pre_q
);
  // R5: timer write reloads a timer-owned prescaler
  assert_pre_tmrclr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_we && !ctl_q[2]) |=> (pre_q == '1));

  // R5: timer write loads the written value
  assert_tmr_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_we |=> (tmr_q == $past(tmr_wdata)));

  // R8: clear or sleep reloads a watchdog-owned prescaler
  assert_pre_wdtclr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((wdt_clear || sleep_enter) && ctl_q[2]) |=> (pre_q == '1));

  // R2: without a write the timer holds or steps by one
  assert_tmr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_we |=> ((tmr_q == $past(tmr_q)) || (tmr_q == $past(tmr_q) + 1'b1)));

  // R6: overflow flag rises only on a wrap to zero
  assert_ovf_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> (($past(tmr_q) == '1) && (tmr_q == '0)));

  // R7: reset request lasts one cycle
  assert_req_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_req |=> !wdt_rst_req);

  // R9: reset request only from an enabled watchdog
  assert_req_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_req |-> $past(wdt_en_q));
endmodule

bind timer_watchdog tw_checker #(.PRE_W(PRE_W), .TMR_W(TMR_W)) u_tw_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ctl_q       (ctl_q),
  .tmr_we      (tmr_we),
  .tmr_wdata   (tmr_wdata),
  .tmr_q       (tmr_q),
  .ovf_flag    (ovf_flag),
  .wdt_clear   (wdt_clear),
  .sleep_enter (sleep_enter),
  .wdt_en_q    (wdt_en_q),
  .wdt_rst_req (wdt_rst_req),
  .pre_q       (pre_q)
);

// File: tb/tb_timer_watchdog.sv
`timescale 1ns/1ps
module tb_timer_watchdog;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ctl_we, wdt_en_we, wdt_en_d, cyc_tick, cnt_pin, tmr_we;
  logic       ovf_clr, wdt_tick, wdt_clear, sleep_enter;
  logic [7:0] ctl_wdata, tmr_wdata;
  logic [7:0] ctl_q, tmr_q, pre_q;
  logic       wdt_en_q, ovf_flag, wdt_rst_req;

  int n_chk  = 0;
  int n_fail = 0;
  int req_cnt = 0;
  int req_mark;

  always #5 clk = ~clk;

  timer_watchdog dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q),
    .wdt_en_we(wdt_en_we), .wdt_en_d(wdt_en_d), .wdt_en_q(wdt_en_q),
    .cyc_tick(cyc_tick), .cnt_pin(cnt_pin), .tmr_we(tmr_we), .tmr_wdata(tmr_wdata),
    .tmr_q(tmr_q), .ovf_clr(ovf_clr), .ovf_flag(ovf_flag), .wdt_tick(wdt_tick),
    .wdt_clear(wdt_clear), .sleep_enter(sleep_enter), .wdt_rst_req(wdt_rst_req),
    .pre_q(pre_q)
  );

  always @(negedge clk) if (rst_n && wdt_rst_req) req_cnt++;

  typedef struct packed {
    logic [2:0] r;
    logic [9:0] n;
    logic [7:0] t;
    logic [7:0] p;
  } vec_t;

  // ratio, timer events, expected timer, expected prescaler (prescaler owned by timer)
  localparam vec_t VECS [6] = '{
    '{3'd1, 10'd9,   8'd2, 8'hF6},
    '{3'd2, 10'd20,  8'd2, 8'hEB},
    '{3'd3, 10'd33,  8'd2, 8'hDE},
    '{3'd7, 10'd256, 8'd1, 8'hFF},
    '{3'd0, 10'd3,   8'd1, 8'hFC},
    '{3'd0, 10'd5,   8'd2, 8'hFA}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0; #1;
  endtask

  task automatic wr_tmr(input logic [7:0] v);
    @(negedge clk); tmr_we = 1'b1; tmr_wdata = v;
    @(negedge clk); tmr_we = 1'b0; #1;
  endtask

  task automatic cyc(input int n);
    @(negedge clk); cyc_tick = 1'b1;
    repeat (n) @(negedge clk);
    cyc_tick = 1'b0; #1;
  endtask

  task automatic wtick(input int n);
    @(negedge clk); wdt_tick = 1'b1;
    repeat (n) @(negedge clk);
    wdt_tick = 1'b0; #1;
  endtask

  task automatic pulse_clr(input bit use_sleep);
    @(negedge clk);
    if (use_sleep) sleep_enter = 1'b1; else wdt_clear = 1'b1;
    @(negedge clk); sleep_enter = 1'b0; wdt_clear = 1'b0; #1;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ctl_we = 0; ctl_wdata = 0; wdt_en_we = 0; wdt_en_d = 0;
    cyc_tick = 0; cnt_pin = 0; tmr_we = 0; tmr_wdata = 0; ovf_clr = 0;
    wdt_tick = 0; wdt_clear = 0; sleep_enter = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; #1;

    // R1 reset state
    chk("R1 ctl", ctl_q, 8'hBF);
    chk("R1 pre", pre_q, 8'hFF);
    chk("R1 tmr", tmr_q, 8'h00);
    chk("R1 ovf", ovf_flag, 1'b0);
    chk("R1 req", wdt_rst_req, 1'b0);
    chk("R1 wen", wdt_en_q, 1'b1);

    // R4 ratio table for the timer
    for (int i = 0; i < 6; i++) begin
      wr_ctl({2'b00, VECS[i].r, 3'b000});
      wr_tmr(8'h00);
      cyc(int'(VECS[i].n));
      chk("R4 tmr", tmr_q, VECS[i].t);
      chk("R4 pre", pre_q, VECS[i].p);
    end

    // R5 timer write with watchdog-owned prescaler leaves it alone
    wr_ctl(8'h04);
    wr_tmr(8'h10);
    chk("R5 tmr load", tmr_q, 8'h10);
    chk("R5 pre kept", pre_q, 8'hFA);

    // R2 undivided internal counting
    cyc(3);
    chk("R2 tmr", tmr_q, 8'h13);
    chk("R2 pre", pre_q, 8'hFA);

    // R6 overflow flag
    wr_tmr(8'hFE);
    cyc(2);
    chk("R6 wrap", tmr_q, 8'h00);
    chk("R6 set", ovf_flag, 1'b1);
    cyc(1);
    chk("R6 held", ovf_flag, 1'b1);
    @(negedge clk); ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0; #1;
    chk("R6 clr", ovf_flag, 1'b0);
    wr_tmr(8'hFF);
    @(negedge clk); cyc_tick = 1'b1; ovf_clr = 1'b1;
    @(negedge clk); cyc_tick = 1'b0; ovf_clr = 1'b0; #1;
    chk("R6 set wins", ovf_flag, 1'b1);

    // R3 external pin, rising then falling
    wr_ctl(8'h05);
    wr_tmr(8'h00);
    @(negedge clk); cnt_pin = 1'b1;
    wait_n(2);
    chk("R3 sync latency", tmr_q, 8'h00);
    wait_n(1);
    chk("R3 rising", tmr_q, 8'h01);
    @(negedge clk); cnt_pin = 1'b0;
    wait_n(4);
    chk("R3 falling ignored", tmr_q, 8'h01);
    wr_ctl(8'h07);
    @(negedge clk); cnt_pin = 1'b1;
    wait_n(4);
    chk("R3 rising ignored", tmr_q, 8'h01);
    @(negedge clk); cnt_pin = 1'b0;
    wait_n(4);
    chk("R3 falling", tmr_q, 8'h02);

    // R8 / R7 watchdog at ratio 0
    wr_ctl(8'h04);
    wtick(3);
    chk("R7 pre dec", pre_q, 8'hF7);
    pulse_clr(1'b0);
    chk("R8 clear pre", pre_q, 8'hFF);
    req_mark = req_cnt;
    wtick(255);
    chk("R8 no early req", req_cnt - req_mark, 0);
    wtick(1);
    chk("R7 req", wdt_rst_req, 1'b1);
    wait_n(1);
    chk("R7 pulse", wdt_rst_req, 1'b0);

    // R8 sleep command
    wtick(4);
    chk("R8 pre before sleep", pre_q, 8'hFB);
    pulse_clr(1'b1);
    chk("R8 sleep pre", pre_q, 8'hFF);

    // R7 ratio 1 doubles the period
    wr_ctl(8'h0C);
    pulse_clr(1'b0);
    req_mark = req_cnt;
    wtick(511);
    chk("R7 ratio1 no early", req_cnt - req_mark, 0);
    wtick(1);
    chk("R7 ratio1 req", wdt_rst_req, 1'b1);

    // R10 / R8 timer-owned prescaler, watchdog undivided
    wr_ctl(8'h00);
    wr_tmr(8'h00);
    cyc(2);
    chk("R10 pre", pre_q, 8'hFD);
    pulse_clr(1'b0);
    chk("R8 clear keeps pre", pre_q, 8'hFD);
    req_mark = req_cnt;
    wtick(255);
    chk("R10 no early", req_cnt - req_mark, 0);
    chk("R10 pre untouched", pre_q, 8'hFD);
    wtick(1);
    chk("R10 req", wdt_rst_req, 1'b1);

    // R9 disabled watchdog
    @(negedge clk); wdt_en_we = 1'b1; wdt_en_d = 1'b0;
    @(negedge clk); wdt_en_we = 1'b0; #1;
    chk("R9 wen", wdt_en_q, 1'b0);
    wr_ctl(8'h04);
    pulse_clr(1'b0);
    req_mark = req_cnt;
    wtick(300);
    chk("R9 no req", req_cnt - req_mark, 0);
    chk("R9 pre", pre_q, 8'hFF);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule